// File: doc/BRIEF.md
# I2C Bit Timing Generator

This block turns single bus-level commands from a transfer engine into correctly timed waveforms on the two I2C lines. It handles five commands: a START from a free bus, a repeated START, a STOP, one written bit and one read bit. Each command runs to completion, then produces a one-cycle completion pulse. For a bit command the pulse also returns the level sampled on the data line.

The block measures every phase in system clock cycles against four programmable counts. The bit-period count sets the full SCL period. The low count sets how long SCL is held low, and SCL stays high for the rest of the period. The edge count sets both the hold time after a START and the setup time before a repeated START or a STOP. The data-setup count sets how long the new SDA value must stand before SCL is released. Suitable settings are about 5/9 of the period for the low count, half the period for the edge count and 1/16 of the period for the data setup.

Both lines are open-drain. The block either pulls a line low or releases it, and it reads back the real line levels. While SCL is released and still reads low, the block waits, so a target can stretch the clock. While sending a 1, if SDA reads low with SCL high, the block reports lost arbitration and releases both lines.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset both lines are released, cmd_ready is high, and done and arb_lost are low.
- R2: START (cmd_op 0) pulls SDA low with SCL released for cfg_edge cycles. It then finishes with SCL held low and SDA held low. The busy time is cfg_edge cycles.
- R3: In every bit, repeated START and STOP, SCL is held low for cfg_low cycles. The previous SDA value stays for the first cfg_low minus cfg_dsetup of those cycles. The new SDA value is present for the last cfg_dsetup cycles.
- R4: With no clock stretching, the SCL high phase of a bit (cmd_op 3 write with cmd_bit, cmd_op 4 read) lasts cfg_period minus cfg_low cycles. SCL is then driven low again.
- R5: While SCL is released but reads low, the high-phase count is frozen. Each stretched cycle lengthens the phase by one cycle.
- R6: A read bit leaves SDA released. done_bit returns the SDA level sampled at high-phase count (cfg_period-cfg_low)/2.
- R7: The driven SDA level changes while SCL reads high only inside START, repeated START or STOP generation.
- R8: Repeated START (cmd_op 1) releases SDA during the low phase. It then keeps SCL released and SDA released for cfg_edge cycles, and SDA low with SCL released for cfg_edge cycles. It ends with SCL held low.
- R9: STOP (cmd_op 2) drives SDA low during the low phase. It then keeps SCL released with SDA low for cfg_edge cycles, and both released for cfg_edge cycles. It leaves both lines released.
- R10: During a written 1, SDA reading low while SCL reads high raises arb_lost for one cycle. It releases both lines and produces no done pulse.
- R11: done is a single-cycle pulse, given once per completed command, and only when cmd_ready is high. cmd_ready stays low from acceptance until completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_period | input | CW | Full SCL period in clocks |
| cfg_low | input | CW | SCL low time in clocks |
| cfg_edge | input | CW | START hold and repeated START / STOP setup time |
| cfg_dsetup | input | CW | SDA setup before SCL release |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | 0 START, 1 repeated START, 2 STOP, 3 write bit, 4 read bit |
| cmd_bit | input | 1 | Bit value for a write |
| cmd_ready | output | 1 | Idle, next command is accepted |
| scl_in | input | 1 | SCL line readback |
| sda_in | input | 1 | SDA line readback |
| scl_drive_low | output | 1 | Pull SCL low when high |
| sda_drive_low | output | 1 | Pull SDA low when high |
| done | output | 1 | Command completed pulse |
| done_bit | output | 1 | Sampled SDA level of the last bit |
| arb_lost | output | 1 | Arbitration lost pulse |

## Verification
A wrong phase state or a miscounted phase shows at the ports in the cycle where the phase should have ended. The busy time and the number of cycles each line spends in each drive combination then differ from the programmed counts, and the bench compares these in every command. A frozen counter that fails to resume would leave cmd_ready low indefinitely. A wrong sample point or a wrong target SDA value shows on done_bit or on the SDA level within that same command.

// File: rtl/i2cbt_pkg.sv
package i2cbt_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RESTART = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ST_HOLD,
        PH_LOW_A,
        PH_LOW_B,
        PH_HIGH,
        PH_RS_SETUP,
        PH_RS_HOLD,
        PH_SP_SETUP,
        PH_SP_BUF
    } phase_e;

    typedef struct packed {
        op_e  op;
        logic tgt_sda_low;
        logic chk_arb;
    } job_t;

    // phases that may not advance until SCL has actually gone high
    function automatic logic waits_on_scl(phase_e p);
        return (p == PH_HIGH) || (p == PH_RS_SETUP) || (p == PH_SP_SETUP);
    endfunction

    // phases that legally move SDA with SCL high
    function automatic logic is_condition(phase_e p);
        return (p == PH_ST_HOLD) || (p == PH_RS_SETUP) || (p == PH_RS_HOLD) ||
               (p == PH_SP_SETUP) || (p == PH_SP_BUF);
    endfunction

    function automatic job_t decode_cmd(logic [2:0] op, logic bit_val);
        job_t j;
        j.chk_arb     = 1'b0;
        j.tgt_sda_low = 1'b0;
        case (op)
            3'd0: j.op = OP_START;
            3'd1: j.op = OP_RESTART;
            3'd2: begin j.op = OP_STOP; j.tgt_sda_low = 1'b1; end
            3'd3: begin
                j.op          = OP_WRITE;
                j.tgt_sda_low = ~bit_val;
                j.chk_arb     = bit_val;
            end
            default: j.op = OP_READ;
        endcase
        return j;
    endfunction

endpackage

// File: rtl/i2cbt_phase_timer.sv
module i2cbt_phase_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          hold,
    input  logic [CW-1:0] len,
    output logic [CW-1:0] count,
    output logic          last
);
    localparam int EW = CW + 1;

    logic [EW-1:0] next_count;

    assign next_count = {1'b0, count} + EW'(1);
    // a zero length behaves as a single cycle
    assign last = next_count >= {1'b0, len};

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count <= '0;
        end else if (!hold) begin
            count <= count + CW'(1);
        end
    end
endmodule

// File: rtl/i2cbt_bit_sense.sv
module i2cbt_bit_sense #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_high,
    input  logic          chk_arb,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] high_len,
    output logic          bit_q,
    output logic          arb_hit
);
    logic at_mid;

    assign at_mid  = in_high && scl_in && (count == (high_len >> 1));
    assign arb_hit = in_high && chk_arb && scl_in && !sda_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
        end else if (at_mid) begin
            bit_q <= sda_in;
        end
    end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
    import i2cbt_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_edge,
    input  logic [CW-1:0] cfg_dsetup,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic          cmd_bit,
    output logic          cmd_ready,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_drive_low,
    output logic          sda_drive_low,
    output logic          done,
    output logic          done_bit,
    output logic          arb_lost
);
    localparam int EW = CW + 1;

    phase_e        phase_q, phase_d;
    job_t          job_q;
    logic          scl_lo_q, sda_lo_q, done_q, arb_q;
    logic [EW-1:0] diff_a, diff_h;
    logic [CW-1:0] len_low_a, len_high, len_cur, cnt;
    logic          last, hold, adv, accept, arb_hit, final_step;

    // phase lengths, saturated at zero
    assign diff_a    = {1'b0, cfg_low} - {1'b0, cfg_dsetup};
    assign diff_h    = {1'b0, cfg_period} - {1'b0, cfg_low};
    assign len_low_a = diff_a[CW] ? '0 : diff_a[CW-1:0];
    assign len_high  = diff_h[CW] ? '0 : diff_h[CW-1:0];

    always_comb begin
        case (phase_q)
            PH_LOW_A: len_cur = len_low_a;
            PH_LOW_B: len_cur = cfg_dsetup;
            PH_HIGH:  len_cur = len_high;
            default:  len_cur = cfg_edge;
        endcase
    end

    assign accept     = cmd_valid && (phase_q == PH_IDLE);
    assign hold       = waits_on_scl(phase_q) && !scl_in;
    assign adv        = (phase_q != PH_IDLE) && last && !hold && !arb_hit;
    assign final_step = adv && ((phase_q == PH_ST_HOLD) || (phase_q == PH_HIGH) ||
                                (phase_q == PH_RS_HOLD) || (phase_q == PH_SP_BUF));

    i2cbt_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (accept || adv || arb_hit),
        .hold    (hold),
        .len     (len_cur),
        .count   (cnt),
        .last    (last)
    );

    i2cbt_bit_sense #(.CW(CW)) u_sense (
        .clk      (clk),
        .rst      (rst),
        .in_high  (phase_q == PH_HIGH),
        .chk_arb  (job_q.chk_arb),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .count    (cnt),
        .high_len (len_high),
        .bit_q    (done_bit),
        .arb_hit  (arb_hit)
    );

    // phase sequencing
    always_comb begin
        phase_d = phase_q;
        if (arb_hit) begin
            phase_d = PH_IDLE;
        end else if (accept) begin
            phase_d = (cmd_op == 3'd0) ? PH_ST_HOLD : PH_LOW_A;
        end else if (adv) begin
            case (phase_q)
                PH_LOW_A: phase_d = PH_LOW_B;
                PH_LOW_B: begin
                    case (job_q.op)
                        OP_RESTART: phase_d = PH_RS_SETUP;
                        OP_STOP:    phase_d = PH_SP_SETUP;
                        default:    phase_d = PH_HIGH;
                    endcase
                end
                PH_RS_SETUP: phase_d = PH_RS_HOLD;
                PH_SP_SETUP: phase_d = PH_SP_BUF;
                default:     phase_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            job_q    <= '0;
            scl_lo_q <= 1'b0;
            sda_lo_q <= 1'b0;
            done_q   <= 1'b0;
            arb_q    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            done_q  <= final_step;
            arb_q   <= arb_hit;
            if (accept) begin
                job_q <= decode_cmd(cmd_op, cmd_bit);
            end
            if (arb_hit) begin
                scl_lo_q <= 1'b0;
                sda_lo_q <= 1'b0;
            end else if (final_step) begin
                case (phase_q)
                    PH_HIGH:   begin scl_lo_q <= 1'b1; sda_lo_q <= job_q.tgt_sda_low; end
                    PH_SP_BUF: begin scl_lo_q <= 1'b0; sda_lo_q <= 1'b0; end
                    default:   begin scl_lo_q <= 1'b1; sda_lo_q <= 1'b1; end
                endcase
            end
        end
    end

    // line drive per phase
    always_comb begin
        case (phase_q)
            PH_IDLE:     sda_drive_low = sda_lo_q;
            PH_ST_HOLD:  sda_drive_low = 1'b1;
            PH_LOW_A:    sda_drive_low = sda_lo_q;
            PH_LOW_B:    sda_drive_low = job_q.tgt_sda_low;
            PH_HIGH:     sda_drive_low = job_q.tgt_sda_low;
            PH_RS_SETUP: sda_drive_low = 1'b0;
            PH_RS_HOLD:  sda_drive_low = 1'b1;
            PH_SP_SETUP: sda_drive_low = 1'b1;
            default:     sda_drive_low = 1'b0;
        endcase
    end

    assign scl_drive_low = ((phase_q == PH_IDLE) && scl_lo_q) ||
                           (phase_q == PH_LOW_A) || (phase_q == PH_LOW_B);
    assign cmd_ready     = (phase_q == PH_IDLE);
    assign done          = done_q;
    assign arb_lost      = arb_q;
endmodule

// File: rtl/i2cbt_checker.sv
module i2cbt_checker
    import i2cbt_pkg::*;
#(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_in,
    input logic          scl_drive_low,
    input logic          sda_drive_low,
    input logic          cmd_ready,
    input logic          done,
    input logic          arb_lost,
    input logic          hold,
    input logic [CW-1:0] cnt,
    input phase_e        phase
);
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cmd_ready && !scl_drive_low && !sda_drive_low && !done && !arb_lost)); // R1

    AST_SDA_STILL_WHEN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (scl_in && $past(scl_in) && (sda_drive_low != $past(sda_drive_low)))
        |-> (is_condition(phase) || is_condition($past(phase)))); // R7

    AST_STRETCH_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(cnt)); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_DONE_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        done |-> cmd_ready); // R11

    AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (rst)
        arb_lost |-> (!scl_drive_low && !sda_drive_low && !done)); // R10
endmodule

bind i2c_bit_timer i2cbt_checker #(.CW(CW)) u_checker (
    .clk           (clk),
    .rst           (rst),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .cmd_ready     (cmd_ready),
    .done          (done),
    .arb_lost      (arb_lost),
    .hold          (hold),
    .cnt           (cnt),
    .phase         (phase_q)
);

// File: tb/i2c_bit_timer_test.sv
module i2c_bit_timer_test;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cfg_period, cfg_low, cfg_edge, cfg_dsetup;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic          cmd_bit = 1'b0;
    logic          cmd_ready, scl_drive_low, sda_drive_low, done, done_bit, arb_lost;
    logic          scl_in, sda_in, stretch, sda_tgt_low = 1'b0;
    int            stretch_left = 0;

    int checks = 0, errors = 0;
    int done_count = 0, busy = 0;
    bit arb_seen = 1'b0, finished = 1'b0;
    int n_scl_low, n_low_sda_rel, n_low_sda_low, n_high, n_rel_rel, n_rel_low;

    typedef struct {
        int    len;
        bit    chk;
        bit    val;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    always #4 clk = ~clk;  // 125 MHz

    assign stretch = (stretch_left > 0);
    assign scl_in  = !(scl_drive_low || stretch);
    assign sda_in  = !(sda_drive_low || sda_tgt_low);

    i2c_bit_timer #(.CW(CW)) uut (
        .clk(clk), .rst(rst),
        .cfg_period(cfg_period), .cfg_low(cfg_low), .cfg_edge(cfg_edge), .cfg_dsetup(cfg_dsetup),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bit(cmd_bit), .cmd_ready(cmd_ready),
        .scl_in(scl_in), .sda_in(sda_in),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .done(done), .done_bit(done_bit), .arb_lost(arb_lost)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (stretch_left > 0 && !scl_drive_low) stretch_left--;
            if (!cmd_ready) busy++;
            if (arb_lost) begin
                arb_seen = 1'b1;
                busy = 0;
            end
            if (done) begin
                done_count++;
                if (sb_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R11: actual unexpected done expected none");
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(busy, e.len, {e.tag, " busy cycles"});
                    if (e.chk) check(int'(done_bit), int'(e.val), {e.tag, " done_bit"});
                end
                busy = 0;
            end
        end
    end

    task automatic do_cmd(input int op, input bit b, input bit push, input int len,
                          input bit chk, input bit val, input string tag);
        exp_t e;
        if (push) begin
            e.len = len; e.chk = chk; e.val = val; e.tag = tag;
            sb_q.push_back(e);
        end
        n_scl_low = 0; n_low_sda_rel = 0; n_low_sda_low = 0;
        n_high = 0; n_rel_rel = 0; n_rel_low = 0;
        cmd_op = 3'(op); cmd_bit = b; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!cmd_ready) begin
            if (scl_drive_low) begin
                n_scl_low++;
                if (sda_drive_low) n_low_sda_low++; else n_low_sda_rel++;
            end else begin
                n_high++;
                if (sda_drive_low) n_rel_low++; else n_rel_rel++;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int dc;
        cfg_period = 12'd36; cfg_low = 12'd20; cfg_edge = 12'd18; cfg_dsetup = 12'd2;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(int'(cmd_ready), 1, "R1 ready");
        check(int'(scl_drive_low), 0, "R1 scl");
        check(int'(sda_drive_low), 0, "R1 sda");
        check(int'(done) + int'(arb_lost), 0, "R1 pulses");

        // START: 18 cycles
        do_cmd(0, 1'b0, 1'b1, 18, 1'b0, 1'b0, "R2");
        check(n_rel_low, 18, "R2 SDA low with SCL released");
        check(int'(scl_drive_low), 1, "R2 SCL held after start");

        // write 1: low 20 (new SDA for 2), high 16
        do_cmd(3, 1'b1, 1'b1, 36, 1'b0, 1'b0, "R4 write1");
        check(n_scl_low, 20, "R3 low length");
        check(n_low_sda_rel, 2, "R3 data setup released");
        check(n_high, 16, "R4 high length");

        // write 0
        do_cmd(3, 1'b0, 1'b1, 36, 1'b0, 1'b0, "R3 write0");
        check(n_low_sda_low, 2, "R3 data setup driven low");
        check(int'(sda_drive_low), 1, "R3 SDA kept after bit");

        // reads
        sda_tgt_low = 1'b0;
        do_cmd(4, 1'b0, 1'b1, 36, 1'b1, 1'b1, "R6 read1");
        sda_tgt_low = 1'b1;
        do_cmd(4, 1'b0, 1'b1, 36, 1'b1, 1'b0, "R6 read0");
        sda_tgt_low = 1'b0;

        // stretched write, 5 cycles
        stretch_left = 6;
        do_cmd(3, 1'b1, 1'b1, 41, 1'b0, 1'b0, "R5 stretch");
        check(n_high, 21, "R5 stretched high length");

        // repeated START
        do_cmd(1, 1'b0, 1'b1, 56, 1'b0, 1'b0, "R8");
        check(n_rel_rel, 18, "R8 setup both released");
        check(n_rel_low, 18, "R8 hold SDA low");
        check(int'(scl_drive_low), 1, "R8 SCL held after restart");

        // second timing set
        cfg_period = 12'd27; cfg_low = 12'd15; cfg_edge = 12'd13; cfg_dsetup = 12'd3;
        @(negedge clk);
        do_cmd(3, 1'b1, 1'b1, 27, 1'b0, 1'b0, "R4 setB");
        check(n_scl_low, 15, "R3 setB low length");
        check(n_low_sda_rel, 3, "R3 setB data setup");
        check(n_high, 12, "R4 setB high length");

        do_cmd(2, 1'b0, 1'b1, 41, 1'b0, 1'b0, "R9");
        check(n_rel_low, 13, "R9 setup SDA low");
        check(n_rel_rel, 13, "R9 bus free time");
        check(int'(scl_drive_low) + int'(sda_drive_low), 0, "R9 released after stop");

        do_cmd(0, 1'b0, 1'b1, 13, 1'b0, 1'b0, "R2 setB");

        // arbitration loss on a written 1
        dc = done_count;
        sda_tgt_low = 1'b1;
        do_cmd(3, 1'b1, 1'b0, 0, 1'b0, 1'b0, "R10");
        sda_tgt_low = 1'b0;
        check(int'(arb_seen), 1, "R10 arb_lost raised");
        check(done_count - dc, 0, "R10 no done on arbitration loss");
        check(int'(scl_drive_low) + int'(sda_drive_low), 0, "R10 lines released");
        check(int'(cmd_ready), 1, "R10 ready after loss");

        repeat (3) @(negedge clk);
        check(done_count, 10, "R11 done count");
        check(sb_q.size(), 0, "R11 scoreboard drained");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule